// File: doc/BRIEF.md
# Manchester LED Message Transmitter

This block sends short diagnostic messages, such as power-on self-test progress codes, by blinking a status LED. The LED hangs on a general-purpose pin that has a pull-up and may also be driven by another agent. Because of that, the block never drives the pin high. It can only enable a low drive or release the pin to high-Z. An optical detector outside the chip watches the LED and recovers the bits.

Software programs a payload byte and a rate code through a two-address register port, then sets a go bit. The block first sends a fixed alternating sync byte, from which the receiver learns the bit rate. It then sends the payload. Both bytes go out most significant bit first, and each bit is Manchester coded, so every bit period contains a mid-bit edge. A short guard interval with the pin released closes the frame. The block then raises a done flag, which software clears by writing 1 to it.

The half-bit period is a whole number of microseconds. A prescaler derives it from the system clock, whose frequency is set by the parameter `CLK_HZ`. The rate code selects 1, 2, 4 or 8 µs. As a result, the line never changes more than once per microsecond.

Top module: `led_manchester_tx`

## Requirements
- R1: After reset, `pin_oe` is 0, busy and done read 0, and the payload and rate registers read 0.
- R2: The register map is as follows. Address 0 is the control register: bit 0 is go (write-only, reads 0), bits [2:1] are the rate code, bit 6 is busy (read-only) and bit 7 is done. Address 1 holds the payload byte. `reg_rdata` always shows the register selected by `reg_addr`.
- R3: A frame carries 16 bits. The first 8 are the sync byte 8'hAA and the next 8 are the payload, each byte most significant bit first.
- R4: `pin_oe`=1 pulls the line low. A 1 bit is sent as a first half with `pin_oe`=1 and a second half with `pin_oe`=0. A 0 bit is sent with the two halves the other way round, so the line changes at every mid-bit.
- R5: Each half-bit lasts (CLK_HZ/1e6)·2^rate clock cycles. The first half-bit starts in the cycle right after the clock edge that samples the go write.
- R6: Busy reads 1 from the cycle after an accepted go until the end of a guard half-bit that follows the 32 data half-bits. During the guard half-bit `pin_oe` is 0.
- R7: Done becomes 1 in the cycle in which busy falls. Writing 1 to control bit 7 clears done, and writing 0 to that bit leaves it set.
- R8: While busy, writes to the payload or to the rate code are ignored, and a go write starts no new frame.
- R9: `pin_oe` never changes twice within CLK_HZ/1e6 clock cycles, even across back-to-back frames.
- R10: Whenever the block is not busy, `pin_oe` is 0, which leaves the line to the pull-up or the other agent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 1 | Register select: 0 control, 1 payload |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pin_oe | output | 1 | 1 enables the low drive on the LED pin, 0 releases it |

## Verification
The assertions assume that `CLK_HZ` is a whole multiple of 1 MHz and at least 2 MHz. They also assume that `reg_wr` and `reg_addr` are held steady for a full clock cycle, with no unknown value present while reset is released. The bench meets this by driving all inputs only on falling edges and by choosing an 8 MHz parameter value. Writes that arrive during a frame are issued deliberately, both in the middle of a bit and alongside a go request, to exercise the ignore rules. Rate codes and payloads are otherwise drawn from a seeded generator, so every write lands on a legal rate code.

// File: rtl/led_tx_pkg.sv
package led_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_GUARD = 2'd2
  } tx_state_e;

  // Alternating preamble of the given width, starting with a 1.
  function automatic logic [15:0] sync_pattern(input int unsigned width);
    logic [15:0] v;
    v = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < int'(width)) v[i] = ((width - 1 - i) % 2) == 0;
    end
    return v;
  endfunction

  // Output-enable level for one half of a Manchester symbol.
  // oe=1 pulls low; a one is low then high.
  function automatic logic half_oe(input logic bit_v, input logic second_half);
    return second_half ? ~bit_v : bit_v;
  endfunction

  // Microseconds per half-bit for a rate code.
  function automatic int unsigned half_us(input int unsigned rate);
    return 32'd1 << rate;
  endfunction

endpackage

// File: rtl/led_tx_regs.sv
module led_tx_regs
  import led_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              frame_end,
  output logic [DATA_W-1:0] data_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              start,
  output logic [DATA_W-1:0] rdata
);

  localparam int GO_BIT   = 0;
  localparam int RATE_LSB = 1;
  localparam int BUSY_BIT = DATA_W - 2;
  localparam int DONE_BIT = DATA_W - 1;

  logic ctrl_wr;
  logic data_wr;
  logic done_q;

  assign ctrl_wr = wr_en && (addr == 1'b0);
  assign data_wr = wr_en && (addr == 1'b1);
  assign start   = ctrl_wr && wdata[GO_BIT] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      rate_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (data_wr && !busy) data_q <= wdata;
      if (ctrl_wr && !busy) rate_q <= wdata[RATE_LSB +: RATE_W];
      if (frame_end) done_q <= 1'b1;
      else if (ctrl_wr && wdata[DONE_BIT]) done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr) begin
      rdata = data_q;
    end else begin
      rdata[RATE_LSB +: RATE_W] = rate_q;
      rdata[BUSY_BIT]           = busy;
      rdata[DONE_BIT]           = done_q;
    end
  end

  AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && data_wr |=> $stable(data_q)); // R8
  AST_RATE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctrl_wr |=> $stable(rate_q)); // R8
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wdata[DONE_BIT] && !frame_end |=> !done_q); // R7
  AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> done_q); // R7

endmodule

// File: rtl/led_tx_timebase.sv
module led_tx_timebase
  import led_tx_pkg::*;
#(
  parameter int US_DIV = 100,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              half_tick
);

  localparam int PS_W  = (US_DIV > 1) ? $clog2(US_DIV) : 1;
  localparam int US_W  = (1 << RATE_W);

  logic [PS_W-1:0] ps_cnt;
  logic [US_W-1:0] us_cnt;
  logic            us_tick;
  logic [US_W-1:0] us_last;

  assign us_last   = US_W'(half_us(32'(rate)) - 1);
  assign us_tick   = run && (ps_cnt == PS_W'(US_DIV - 1));
  assign half_tick = us_tick && (us_cnt == us_last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      ps_cnt <= '0;
      us_cnt <= '0;
    end else begin
      ps_cnt <= us_tick ? '0 : ps_cnt + 1'b1;
      if (us_tick) us_cnt <= half_tick ? '0 : us_cnt + 1'b1;
    end
  end

  AST_RATE_STABLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && !restart |-> $stable(rate)); // R8

endmodule

// File: rtl/led_tx_serializer.sv
module led_tx_serializer
  import led_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic              half_tick,
  output logic              busy,
  output logic              pin_oe,
  output logic              frame_end
);

  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam logic [DATA_W-1:0] SYNC = sync_pattern(DATA_W)[DATA_W-1:0];

  tx_state_e             state;
  logic [FRAME_BITS-1:0] shreg;
  logic [BIT_W-1:0]      bit_cnt;
  logic                  phase;
  logic                  last_bit;

  assign last_bit  = (bit_cnt == BIT_W'(FRAME_BITS - 1));
  assign busy      = (state != TX_IDLE);
  assign frame_end = (state == TX_GUARD) && half_tick;
  assign pin_oe    = (state == TX_SEND) && half_oe(shreg[FRAME_BITS-1], phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
      phase   <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (start) begin
            shreg   <= {SYNC, data};
            bit_cnt <= '0;
            phase   <= 1'b0;
            state   <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (half_tick) begin
            if (!phase) begin
              phase <= 1'b1;
            end else begin
              phase <= 1'b0;
              shreg <= shreg << 1;
              if (last_bit) state <= TX_GUARD;
              else bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        TX_GUARD: begin
          if (half_tick) state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  AST_MID_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_SEND) && half_tick && !phase |=> pin_oe != $past(pin_oe)); // R4
  AST_GUARD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_GUARD) |-> !pin_oe); // R6
  AST_START_ENTERS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE) && start |=> (state == TX_SEND) && !phase && (bit_cnt == '0)); // R5

endmodule

// File: rtl/led_manchester_tx.sv
module led_manchester_tx
  import led_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       pin_oe
);

  localparam int DATA_W = 8;
  localparam int RATE_W = 2;
  localparam int US_DIV = int'(CLK_HZ / 1_000_000);
  localparam int GAP_W  = $clog2(US_DIV + 1);

  logic [DATA_W-1:0] data_q;
  logic [RATE_W-1:0] rate_q;
  logic              start;
  logic              busy;
  logic              frame_end;
  logic              half_tick;

  led_tx_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .busy      (busy),
    .frame_end (frame_end),
    .data_q    (data_q),
    .rate_q    (rate_q),
    .start     (start),
    .rdata     (reg_rdata)
  );

  led_tx_timebase #(.US_DIV(US_DIV), .RATE_W(RATE_W)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .restart   (start),
    .rate      (rate_q),
    .half_tick (half_tick)
  );

  led_tx_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .data      (data_q),
    .half_tick (half_tick),
    .busy      (busy),
    .pin_oe    (pin_oe),
    .frame_end (frame_end)
  );

  // Transition spacing monitor for the assertion below.
  logic             oe_prev;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_prev <= 1'b0;
      gap     <= GAP_W'(US_DIV);
    end else begin
      oe_prev <= pin_oe;
      if (pin_oe != oe_prev) gap <= GAP_W'(1);
      else if (gap < GAP_W'(US_DIV)) gap <= gap + 1'b1;
    end
  end

  AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != oe_prev) |-> (gap >= GAP_W'(US_DIV))); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pin_oe); // R10
  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy && reg_rdata[7] == (reg_addr ? data_q[7] : 1'b1)); // R6

endmodule

// File: tb/tb_led_manchester_tx.sv
module tb_led_manchester_tx;

  localparam int unsigned CLK_HZ = 8_000_000;
  localparam int US_DIV = CLK_HZ / 1_000_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       pin_oe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  led_manchester_tx #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_oe(pin_oe)
  );

  function automatic int half_cycles(input int rate);
    return US_DIV * (2 ** rate);
  endfunction

  // Expected pin_oe for half index k (0..31) of a frame carrying payload d.
  function automatic logic exp_oe(input logic [7:0] d, input int k);
    logic [15:0] word;
    logic        b;
    word = {8'b1010_1010, d};
    b = word[15 - (k / 2)];
    if ((k % 2) == 0) return b;
    return !b;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Sends a frame and checks every half-bit at its midpoint.
  task automatic frame(input logic [7:0] d, input int rate, input bit meddle);
    int h;
    logic [7:0] r;
    h = half_cycles(rate);
    wr(1'b1, d);
    wr(1'b0, {5'b0, 2'(rate), 1'b1});
    for (int k = 0; k < 33; k++) begin
      repeat (h / 2) @(negedge clk);
      #1;
      if (k < 32) check($sformatf("R3 R4 R5 half %0d", k), {7'b0, pin_oe}, {7'b0, exp_oe(d, k)});
      else check("R6 guard released", {7'b0, pin_oe}, 8'h00);
      if (k == 0) begin
        rd(1'b0, r);
        check("R2 R6 busy set, go reads 0, rate readback", r & 8'h47, {1'b0, 1'b1, 3'b0, 2'(rate), 1'b0});
      end
      if (k == 32) begin
        rd(1'b0, r);
        check("R6 busy through guard", {7'b0, r[6]}, 8'h01);
      end
      if (meddle && k == 9) begin
        wr(1'b1, ~d);
        wr(1'b0, {5'b0, 2'(rate + 1), 1'b1});
        repeat (h - h / 2 - 2) @(negedge clk);
      end else begin
        repeat (h - h / 2) @(negedge clk);
      end
    end
    #1;
    rd(1'b0, r);
    check("R6 R7 busy low, done set at end", r & 8'hC0, 8'h80);
    check("R10 idle released", {7'b0, pin_oe}, 8'h00);
    if (meddle) begin
      rd(1'b1, r);
      check("R8 payload kept", r, d);
      rd(1'b0, r);
      check("R8 rate kept", {6'b0, r[2:1]}, 8'(rate));
      repeat (3 * US_DIV) @(negedge clk);
      #1;
      rd(1'b0, r);
      check("R8 go while busy ignored", {7'b0, r[6]}, 8'h00);
      check("R8 R10 pin idle", {7'b0, pin_oe}, 8'h00);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5eed_1d5));
    repeat (3) @(negedge clk);
    rd(1'b0, r);
    check("R1 control after reset", r, 8'h00);
    rd(1'b1, r);
    check("R1 payload after reset", r, 8'h00);
    check("R1 pin after reset", {7'b0, pin_oe}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    frame(8'h00, 0, 1'b0);
    frame(8'hFF, 1, 1'b0);
    // R7: writing 0 to done keeps it; writing 1 clears it
    wr(1'b0, 8'h00);
    rd(1'b0, r);
    check("R7 done kept on write 0", {7'b0, r[7]}, 8'h01);
    wr(1'b0, 8'h80);
    rd(1'b0, r);
    check("R7 done cleared by write 1", {7'b0, r[7]}, 8'h00);
    frame(8'h5A, 3, 1'b1);
    // R9: back-to-back frames, go issued right after busy falls
    frame(8'h01, 0, 1'b0);
    frame(8'h80, 0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      frame(8'($urandom), int'($urandom % 3), (i == 2));
    end
    report();
  end

endmodule